// File: doc/BRIEF.md
# Timer Channel Set/Clear Control Front End

This block sits between a simple register port and a bank of timer counter cores. Every channel has its own 64-byte address window. Four value words are stored in each window: count, reload, match A and match B. A write to a value word is stored and also passed on to the counter cores. Each channel also has a 4-bit control nibble. Software never writes this nibble directly. It changes only through a write-one-to-set register and a write-one-to-clear register, so two agents that touch different bits cannot overwrite each other's changes.

The block sequences every control change safely. A set write applies its configuration bits first and turns the enable on one cycle later. A clear write turns the enable off first and removes the configuration bits one cycle later. Each channel also has a sticky interrupt-status bit. An event input sets it, and a clear write with bit 16 set removes it. Per-channel pulse outputs mark each enable rise, each enable fall and each configuration change, so the counter cores can act on them.

Top module: `tmr_setclr_hub`

## Requirements
- R1: After reset every control nibble, every status bit and every pulse output is 0, and no response is valid.
- R2: The channel index is address bits [ADDR_W-1:6] and the window offset is bits [5:0]. Offsets 0x00, 0x04, 0x08 and 0x0C (selector = offset[3:2]) hold count, reload, match A and match B. A write to one of them is stored for read-back and shows on val_we_o, val_chan_o, val_sel_o and val_data_o for one cycle after the write edge.
- R3: Nibble bits are: bit0 enable, bit1 clock source, bit2 overflow-interrupt enable, bit3 pulse mode. A write to offset 0x10 sets to 1 each bit written as 1. Bits written as 0 stay as they are.
- R4: A set write changes bits 3:1 at its own write edge and bit0 at the next edge. en_pulse_o is high for the one cycle after the enable rises.
- R5: A write to offset 0x14 clears each nibble bit written as 1. Bit0 falls at the write edge, with dis_pulse_o high for one cycle, and bits 3:1 fall at the next edge.
- R6: cfg_pulse_o for a channel is high for exactly one cycle after any edge that changes that channel's bits 3:1.
- R7: An event_i bit sets that channel's status bit. The bit holds until a write to offset 0x14 with data bit 16 set. If an event and that clear come in the same cycle, the bit ends up set.
- R8: A read returns data with rsp_valid high in the cycle after the request. Offset 0x10 reads the status bit in bit 16 and the nibble in bits 3:0, with all other bits 0.
- R9: An access whose channel index is NCH or more reads zero. It changes no nibble, no status bit and no value word, and it raises no val_we_o.
- R10: Reads of offset 0x14 and of offsets 0x18 to 0x3C return zero. Writes to offsets 0x18 to 0x3C are ignored.
- R11: A control write that follows the previous one by a single cycle is evaluated against the nibble as if the earlier write had fully finished. A set of 0x3 followed at once by a clear of 0x1 therefore leaves 0x2 and gives no en_pulse_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address: channel and window offset |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data |
| event_i | input | NCH | Per-channel interrupt event |
| ctrl_o | output | NCH*4 | Control nibbles; channel c at [4c+3:4c] |
| irq_sts_o | output | NCH | Sticky status bits |
| en_pulse_o | output | NCH | Enable rose |
| dis_pulse_o | output | NCH | Enable fell |
| cfg_pulse_o | output | NCH | Configuration bits changed |
| val_we_o | output | 1 | Value-word write forwarded to cores |
| val_chan_o | output | CH_W | Channel of forwarded write |
| val_sel_o | output | 2 | Word selector of forwarded write |
| val_data_o | output | 32 | Forwarded data |

## Verification
A wrong nibble shows on ctrl_o right after the edge that made it. If the pending second phase is lost or misplaced, the enable or the configuration bits land one edge early, one edge late, or never, and the pulse outputs mark the same error. Address aliasing, where an out-of-range channel hits a real one, shows as a changed nibble or a changed value word on a later read-back. A status bit that fails to hold, or loses against a clear in the same cycle, shows on irq_sts_o one cycle later.

// File: rtl/tmr_sc_pkg.sv
package tmr_sc_pkg;
  localparam int unsigned NIB_W   = 4;
  localparam int unsigned DATA_W  = 32;
  localparam int unsigned WIN_LSB = 6;
  localparam int unsigned STS_BIT = 16;

  localparam int unsigned CB_EN    = 0;
  localparam int unsigned CB_CLK   = 1;
  localparam int unsigned CB_OVF   = 2;
  localparam int unsigned CB_PULSE = 3;

  localparam logic [5:0] OFS_SET = 6'h10;
  localparam logic [5:0] OFS_CLR = 6'h14;

  typedef enum logic [1:0] {
    RK_ZERO = 2'd0,
    RK_VAL  = 2'd1,
    RK_CTL  = 2'd2
  } rsp_kind_t;
endpackage

// File: rtl/tmr_sc_decode.sv
module tmr_sc_decode #(
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned NCH    = 8,
  parameter int unsigned CH_W   = 3
) (
  input  logic              req_valid,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  output logic [CH_W-1:0]   chan,
  output logic              chan_ok,
  output logic [1:0]        sel,
  output logic              val_wr,
  output logic              val_rd,
  output logic              set_wr,
  output logic              clr_wr,
  output logic              ctl_rd
);
  import tmr_sc_pkg::*;
  localparam int unsigned RAW_W = ADDR_W - WIN_LSB;

  logic [RAW_W-1:0] raw_ch;
  logic [5:0]       ofs;
  logic             is_val;

  always_comb begin
    raw_ch  = req_addr[ADDR_W-1:WIN_LSB];
    ofs     = req_addr[WIN_LSB-1:0];
    chan    = raw_ch[CH_W-1:0];
    chan_ok = 32'(raw_ch) < NCH;
    sel     = ofs[3:2];
    is_val  = (ofs[5:4] == 2'b00) && (ofs[1:0] == 2'b00);
    val_wr  = req_valid && req_we  && chan_ok && is_val;
    val_rd  = req_valid && !req_we && chan_ok && is_val;
    set_wr  = req_valid && req_we  && chan_ok && (ofs == OFS_SET);
    clr_wr  = req_valid && req_we  && chan_ok && (ofs == OFS_CLR);
    ctl_rd  = req_valid && !req_we && chan_ok && (ofs == OFS_SET);
  end
endmodule

// File: rtl/tmr_sc_ctrl.sv
module tmr_sc_ctrl #(
  parameter int unsigned NCH  = 8,
  parameter int unsigned CH_W = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            set_wr,
  input  logic            clr_wr,
  input  logic [CH_W-1:0] chan,
  input  logic [3:0]      wbits,
  output logic [NCH*4-1:0] nib_o,
  output logic [NCH-1:0]  en_pulse,
  output logic [NCH-1:0]  dis_pulse,
  output logic [NCH-1:0]  cfg_pulse
);
  import tmr_sc_pkg::*;

  logic [3:0]      nib_q  [NCH];
  logic [3:0]      view   [NCH];
  logic [3:0]      nxt    [NCH];
  logic            pend_v;
  logic            pend_set;
  logic [CH_W-1:0] pend_ch;
  logic [3:0]      pend_bits;

  logic [3:0] cur;
  logic [3:0] fresh;
  logic [3:0] hit;
  logic [3:0] first;
  logic [3:0] second;

  // Nibble as it stands once the pending second phase has landed.
  for (genvar c = 0; c < NCH; c++) begin : g_view
    always_comb begin
      view[c] = nib_q[c];
      if (pend_v && pend_ch == CH_W'(c)) begin
        view[c] = pend_set ? (nib_q[c] | pend_bits) : (nib_q[c] & ~pend_bits);
      end
    end
  end

  always_comb begin
    cur    = view[chan];
    fresh  = wbits & ~cur;
    hit    = wbits & cur;
    first  = '0;
    second = '0;
    if (set_wr) begin
      first  = {fresh[3:1], 1'b0};
      second = {3'b000, fresh[CB_EN]};
    end else if (clr_wr) begin
      first  = {3'b000, hit[CB_EN]};
      second = {hit[3:1], 1'b0};
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_nib
    always_comb begin
      nxt[c] = view[c];
      if (set_wr && chan == CH_W'(c)) nxt[c] = view[c] | first;
      if (clr_wr && chan == CH_W'(c)) nxt[c] = view[c] & ~first;
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        nib_q[c]     <= '0;
        en_pulse[c]  <= 1'b0;
        dis_pulse[c] <= 1'b0;
        cfg_pulse[c] <= 1'b0;
      end else begin
        nib_q[c]     <= nxt[c];
        en_pulse[c]  <= !nib_q[c][CB_EN] && nxt[c][CB_EN];
        dis_pulse[c] <= nib_q[c][CB_EN] && !nxt[c][CB_EN];
        cfg_pulse[c] <= nib_q[c][3:1] != nxt[c][3:1];
      end
    end

    assign nib_o[c*4 +: 4] = nib_q[c];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_v    <= 1'b0;
      pend_set  <= 1'b0;
      pend_ch   <= '0;
      pend_bits <= '0;
    end else begin
      pend_v    <= (set_wr || clr_wr) && (second != 4'b0000);
      pend_set  <= set_wr;
      pend_ch   <= chan;
      pend_bits <= second;
    end
  end

  // R4: an enable rise comes from a set write two edges back.
  assert_enable_last_R4: assert property (@(posedge clk) disable iff (rst)
    (|en_pulse) |-> $past(set_wr, 2));

  // R5: an enable fall comes from the clear write on the edge just before.
  assert_disable_first_R5: assert property (@(posedge clk) disable iff (rst)
    (|dis_pulse) |-> $past(clr_wr));
endmodule

// File: rtl/tmr_sc_status.sv
module tmr_sc_status #(
  parameter int unsigned NCH  = 8,
  parameter int unsigned CH_W = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NCH-1:0]  event_i,
  input  logic            clr_stb,
  input  logic [CH_W-1:0] chan,
  output logic [NCH-1:0]  sts_q
);
  logic [NCH-1:0] clr_mask;

  for (genvar c = 0; c < NCH; c++) begin : g_sts
    assign clr_mask[c] = clr_stb && chan == CH_W'(c);

    always_ff @(posedge clk) begin
      if (rst) sts_q[c] <= 1'b0;
      else     sts_q[c] <= (sts_q[c] && !clr_mask[c]) || event_i[c];
    end

    // R7: held until cleared.
    assert_sticky_R7: assert property (@(posedge clk) disable iff (rst)
      (sts_q[c] && !clr_mask[c]) |=> sts_q[c]);
    // R7: event wins over a clear in the same cycle.
    assert_set_wins_R7: assert property (@(posedge clk) disable iff (rst)
      event_i[c] |=> sts_q[c]);
  end
endmodule

// File: rtl/tmr_sc_valregs.sv
module tmr_sc_valregs #(
  parameter int unsigned NCH    = 8,
  parameter int unsigned CH_W   = 3,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic              re,
  input  logic [CH_W-1:0]   chan,
  input  logic [1:0]        sel,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata_q,
  output logic              fwd_we,
  output logic [CH_W-1:0]   fwd_chan,
  output logic [1:0]        fwd_sel,
  output logic [DATA_W-1:0] fwd_data
);
  localparam int unsigned DEPTH = NCH * 4;
  localparam int unsigned AW    = CH_W + 2;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0]     idx;

  assign idx = {chan, sel};

  // Plain single-port array so a block RAM can be inferred.
  always_ff @(posedge clk) begin
    if (we) mem[idx] <= wdata;
    if (re) rdata_q  <= mem[idx];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fwd_we   <= 1'b0;
      fwd_chan <= '0;
      fwd_sel  <= '0;
      fwd_data <= '0;
    end else begin
      fwd_we <= we;
      if (we) begin
        fwd_chan <= chan;
        fwd_sel  <= sel;
        fwd_data <= wdata;
      end
    end
  end
endmodule

// File: rtl/tmr_setclr_hub.sv
module tmr_setclr_hub #(
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned NCH    = 8,
  parameter int unsigned CH_W   = $clog2(NCH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  output logic              rsp_valid,
  output logic [31:0]       rsp_rdata,
  input  logic [NCH-1:0]    event_i,
  output logic [NCH*4-1:0]  ctrl_o,
  output logic [NCH-1:0]    irq_sts_o,
  output logic [NCH-1:0]    en_pulse_o,
  output logic [NCH-1:0]    dis_pulse_o,
  output logic [NCH-1:0]    cfg_pulse_o,
  output logic              val_we_o,
  output logic [CH_W-1:0]   val_chan_o,
  output logic [1:0]        val_sel_o,
  output logic [31:0]       val_data_o
);
  import tmr_sc_pkg::*;

  logic [CH_W-1:0] chan;
  logic            chan_ok;
  logic [1:0]      sel;
  logic            val_wr, val_rd, set_wr, clr_wr, ctl_rd;
  logic [31:0]     val_rdata;
  rsp_kind_t       kind_q;
  logic [31:0]     ctl_word_q;

  tmr_sc_decode #(.ADDR_W(ADDR_W), .NCH(NCH), .CH_W(CH_W)) u_dec (
    .req_valid(req_valid), .req_we(req_we), .req_addr(req_addr),
    .chan(chan), .chan_ok(chan_ok), .sel(sel),
    .val_wr(val_wr), .val_rd(val_rd), .set_wr(set_wr),
    .clr_wr(clr_wr), .ctl_rd(ctl_rd)
  );

  tmr_sc_ctrl #(.NCH(NCH), .CH_W(CH_W)) u_ctrl (
    .clk(clk), .rst(rst), .set_wr(set_wr), .clr_wr(clr_wr),
    .chan(chan), .wbits(req_wdata[3:0]), .nib_o(ctrl_o),
    .en_pulse(en_pulse_o), .dis_pulse(dis_pulse_o), .cfg_pulse(cfg_pulse_o)
  );

  tmr_sc_status #(.NCH(NCH), .CH_W(CH_W)) u_sts (
    .clk(clk), .rst(rst), .event_i(event_i),
    .clr_stb(clr_wr && req_wdata[STS_BIT]), .chan(chan), .sts_q(irq_sts_o)
  );

  tmr_sc_valregs #(.NCH(NCH), .CH_W(CH_W), .DATA_W(DATA_W)) u_val (
    .clk(clk), .rst(rst), .we(val_wr), .re(val_rd), .chan(chan), .sel(sel),
    .wdata(req_wdata), .rdata_q(val_rdata),
    .fwd_we(val_we_o), .fwd_chan(val_chan_o), .fwd_sel(val_sel_o),
    .fwd_data(val_data_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid  <= 1'b0;
      kind_q     <= RK_ZERO;
      ctl_word_q <= '0;
    end else begin
      rsp_valid  <= req_valid && !req_we;
      kind_q     <= val_rd ? RK_VAL : (ctl_rd ? RK_CTL : RK_ZERO);
      ctl_word_q <= '0;
      if (ctl_rd) begin
        ctl_word_q[STS_BIT] <= irq_sts_o[chan];
        ctl_word_q[3:0]     <= ctrl_o[chan*4 +: 4];
      end
    end
  end

  always_comb begin
    case (kind_q)
      RK_VAL:  rsp_rdata = val_rdata;
      RK_CTL:  rsp_rdata = ctl_word_q;
      default: rsp_rdata = '0;
    endcase
  end

  // R8: one-cycle read latency, and no unrequested response.
  assert_rsp_latency_R8: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_we) |=> rsp_valid);
  assert_no_stray_rsp_R8: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $past(req_valid && !req_we));
  // R9: out-of-range channel never forwards a value write.
  assert_bad_chan_R9: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_we && !chan_ok) |=> !val_we_o);
endmodule

// File: tb/sim_tmr_setclr_hub.sv
module sim_tmr_setclr_hub;
  localparam int CLK_P = 10;
  localparam int NCH = 8;
  localparam int AW = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0, req_we = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic rsp_valid;
  logic [31:0] rsp_rdata;
  logic [NCH-1:0] event_i = '0;
  logic [NCH*4-1:0] ctrl_o;
  logic [NCH-1:0] irq_sts_o, en_pulse_o, dis_pulse_o, cfg_pulse_o;
  logic val_we_o;
  logic [2:0] val_chan_o;
  logic [1:0] val_sel_o;
  logic [31:0] val_data_o;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_P/2) clk = ~clk;

  tmr_setclr_hub #(.ADDR_W(AW), .NCH(NCH)) u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_we(req_we),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .event_i(event_i), .ctrl_o(ctrl_o),
    .irq_sts_o(irq_sts_o), .en_pulse_o(en_pulse_o), .dis_pulse_o(dis_pulse_o),
    .cfg_pulse_o(cfg_pulse_o), .val_we_o(val_we_o), .val_chan_o(val_chan_o),
    .val_sel_o(val_sel_o), .val_data_o(val_data_o)
  );

  function automatic logic [AW-1:0] mk(int ch, int ofs);
    return AW'((ch << 6) | ofs);
  endfunction

  function automatic logic [31:0] vpat(int ch, int sel);
    return 32'h1000_0000 * ch + 32'h0011_0000 * sel + 32'h5A + ch * 3;
  endfunction

  function automatic logic [3:0] nib(int ch);
    return ctrl_o[ch*4 +: 4];
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wr(int ch, int ofs, logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_we = 1'b1; req_addr = mk(ch, ofs); req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_we = 1'b0;
  endtask

  task automatic rd(int ch, int ofs, output logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_we = 1'b0; req_addr = mk(ch, ofs);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R8 rsp_valid", 32'(rsp_valid), 32'd1);
    d = rsp_rdata;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic [NCH*4-1:0] snap;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1 ctrl", 32'(ctrl_o), 32'd0);
    chk("R1 sts", 32'(irq_sts_o), 32'd0);
    chk("R1 pulses", 32'({en_pulse_o, dis_pulse_o, cfg_pulse_o}), 32'd0);
    chk("R1 rsp", 32'(rsp_valid), 32'd0);

    // R2 value words: write every channel/selector, check forwarding, read back
    for (int ch = 0; ch < NCH; ch++)
      for (int s = 0; s < 4; s++) begin
        wr(ch, s * 4, vpat(ch, s));
        chk("R2 fwd", {val_we_o, 26'd0, val_chan_o, val_sel_o}, {1'b1, 26'd0, 3'(ch), 2'(s)});
        chk("R2 fwd data", val_data_o, vpat(ch, s));
        tick();
        chk("R2 fwd one cycle", 32'(val_we_o), 32'd0);
      end
    for (int ch = 0; ch < NCH; ch++)
      for (int s = 0; s < 4; s++) begin
        rd(ch, s * 4, d);
        chk("R2 readback", d, vpat(ch, s));
      end

    // R3 exhaustive set/clear on channel 3
    for (int s = 0; s < 16; s++)
      for (int w = 0; w < 16; w++) begin
        wr(3, 'h14, 32'hF); tick();
        wr(3, 'h10, 32'(s)); tick();
        wr(3, 'h10, 32'(w)); tick();
        rd(3, 'h10, d);
        chk("R3 set", d, 32'(s | w));
        wr(3, 'h14, 32'(w)); tick();
        rd(3, 'h10, d);
        chk("R5 clear", d, 32'((s | w) & ~w));
      end

    // R4/R6 set order on channel 1
    wr(1, 'h10, 32'hF);
    chk("R4 cfg first", 32'(nib(1)), 32'hE);
    chk("R6 cfg pulse", 32'(cfg_pulse_o), 32'h02);
    chk("R4 no early en", 32'(en_pulse_o), 32'h0);
    tick();
    chk("R4 enable last", 32'(nib(1)), 32'hF);
    chk("R4 en pulse", 32'(en_pulse_o), 32'h02);
    chk("R6 cfg pulse once", 32'(cfg_pulse_o), 32'h0);
    tick();
    chk("R4 en pulse once", 32'(en_pulse_o), 32'h0);
    wr(1, 'h10, 32'hF);
    chk("R3 no change", 32'(nib(1)), 32'hF);
    chk("R6 no pulse", 32'({en_pulse_o, dis_pulse_o, cfg_pulse_o}), 32'd0);
    // R5 clear order
    wr(1, 'h14, 32'hF);
    chk("R5 disable first", 32'(nib(1)), 32'hE);
    chk("R5 dis pulse", 32'(dis_pulse_o), 32'h02);
    chk("R6 no cfg yet", 32'(cfg_pulse_o), 32'h0);
    tick();
    chk("R5 cfg after", 32'(nib(1)), 32'h0);
    chk("R6 cfg pulse clr", 32'(cfg_pulse_o), 32'h02);

    // R7 status on channel 5
    @(negedge clk); event_i[5] = 1'b1;
    @(negedge clk); event_i[5] = 1'b0;
    chk("R7 set", 32'(irq_sts_o), 32'h20);
    repeat (3) tick();
    chk("R7 hold", 32'(irq_sts_o), 32'h20);
    rd(5, 'h10, d);
    chk("R8 ctl word", d, 32'h0001_0000);
    wr(5, 'h14, 32'h0);
    chk("R7 no bit16 keeps", 32'(irq_sts_o), 32'h20);
    wr(5, 'h14, 32'h1_0000);
    chk("R7 clear", 32'(irq_sts_o), 32'h0);
    @(negedge clk);
    event_i[5] = 1'b1;
    req_valid = 1'b1; req_we = 1'b1; req_addr = mk(5, 'h14); req_wdata = 32'h1_0000;
    @(negedge clk);
    event_i[5] = 1'b0; req_valid = 1'b0; req_we = 1'b0;
    chk("R7 set wins", 32'(irq_sts_o), 32'h20);
    wr(5, 'h10, 32'h5); tick();
    rd(5, 'h10, d);
    chk("R8 ctl word both", d, 32'h0001_0005);

    // R9 out-of-range channels
    snap = ctrl_o;
    for (int ch = NCH; ch < 16; ch++) begin
      wr(ch, 'h10, 32'hF);
      chk("R9 no val_we", 32'(val_we_o), 32'd0);
      wr(ch, 'h04, 32'hDEAD_BEEF);
      chk("R9 no fwd", 32'(val_we_o), 32'd0);
      wr(ch, 'h14, 32'h1_000F);
      tick();
      chk("R9 ctrl same", 32'(ctrl_o), 32'(snap));
      chk("R9 sts same", 32'(irq_sts_o), 32'h20);
      rd(ch, 'h04, d);
      chk("R9 read zero", d, 32'd0);
      rd(ch, 'h10, d);
      chk("R9 ctl read zero", d, 32'd0);
    end
    for (int ch = 0; ch < NCH; ch++) begin
      rd(ch, 'h04, d);
      chk("R9 no alias", d, vpat(ch, 1));
    end

    // R10 unused offsets
    rd(2, 'h14, d); chk("R10 clr reads zero", d, 32'd0);
    rd(2, 'h18, d); chk("R10 0x18 zero", d, 32'd0);
    rd(2, 'h3C, d); chk("R10 0x3C zero", d, 32'd0);
    snap = ctrl_o;
    wr(2, 'h18, 32'hF);
    chk("R10 no fwd", 32'(val_we_o), 32'd0);
    tick();
    chk("R10 ctrl same", 32'(ctrl_o), 32'(snap));

    // R11 back-to-back on channel 6
    @(negedge clk);
    req_valid = 1'b1; req_we = 1'b1; req_addr = mk(6, 'h10); req_wdata = 32'h3;
    @(negedge clk);
    chk("R11 first phase", 32'(nib(6)), 32'h2);
    req_addr = mk(6, 'h14); req_wdata = 32'h1;
    @(negedge clk);
    req_valid = 1'b0; req_we = 1'b0;
    chk("R11 result", 32'(nib(6)), 32'h2);
    chk("R11 no en pulse", 32'(en_pulse_o), 32'h0);
    tick();
    chk("R11 settled", 32'(nib(6)), 32'h2);
    chk("R11 no pulse", 32'({en_pulse_o, dis_pulse_o}), 32'h0);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule